// File: doc/BRIEF.md
# Triplicated Pixel Configuration Shift Chain

This block is the configuration store for the pixels of a group of readout columns. A controller at the end of the columns loads it bit by bit over a serial data line, using a shift enable and the chain clock. Each pixel keeps one configuration byte: a 5-bit threshold trim code, a mask bit, a test-pulse enable and one spare bit. The trim code, mask and test-pulse enable drive the pixel front-end as parallel outputs. The bit at the far end of the chain comes out on a serial output, so a controller can read back what it wrote.

Every stored bit is held in three flip-flops. All outputs come from a bitwise two-of-three vote. While the chain is idle, any copy that disagrees with the vote is written back to the voted value on the next clock, and a single-cycle flag shows that a repair took place. While the chain shifts, every copy of a stage loads the voted value of the stage before it, so a corrupted copy is never passed downstream. An upset strobe lets one copy of one bit be inverted on purpose. This models a particle strike.

Top module: `tmr_cfg_chain`

## Requirements
- R1: After reset every stored bit is 0. All pixel outputs, `cfg_sdo` and `seu_corrected` are 0.
- R2: On each clock with `cfg_shift_en` high, stage 0 takes `cfg_sdi` and stage i takes the voted value of stage i-1. After NBITS shifts, the first bit shifted in sits in stage NBITS-1.
- R3: Pixel p owns stages 8p to 8p+7. Stages 8p+0 to 8p+4 are trim bits 0 to 4 on `pix_trim[5p +: 5]`. Stage 8p+5 is `pix_mask[p]`, stage 8p+6 is `pix_tpen[p]`, and stage 8p+7 is the spare bit.
- R4: `cfg_sdo` is always the voted value of stage NBITS-1.
- R5: With `cfg_shift_en` low, the voted contents do not change.
- R6: When `upset_en` is high with `cfg_shift_en` low, the copy picked by `upset_copy` (0, 1 or 2) of stage `upset_bit` is inverted at the next clock. No output changes.
- R7: `seu_corrected` is high for exactly the one cycle after the clock edge on which a disagreeing copy is rewritten. That edge is the one after the upset.
- R8: The repair restores the inverted copy in place. A later upset of a different copy of the same bit still leaves the outputs unchanged.
- R9: `upset_en` has no effect while `cfg_shift_en` is high, and none when `upset_copy` is 3.
- R10: Shifting out of a stage that holds an upset copy passes on only the voted value. `seu_corrected` stays 0 after any edge taken with `cfg_shift_en` high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Chain clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_sdi | input | 1 | Serial configuration data in |
| cfg_shift_en | input | 1 | Shift enable, one bit per clock while high |
| upset_en | input | 1 | Invert one stored copy (strike model) |
| upset_bit | input | IDX_W (7) | Stage index of the copy to invert |
| upset_copy | input | 2 | Copy to invert: 0, 1, 2; 3 means none |
| cfg_sdo | output | 1 | Voted value of the last stage |
| seu_corrected | output | 1 | One-cycle pulse after an in-place repair |
| pix_trim | output | NPIX*5 (80) | Voted trim codes, 5 bits per pixel |
| pix_mask | output | NPIX (16) | Voted mask bit per pixel |
| pix_tpen | output | NPIX (16) | Voted test-pulse enable per pixel |

## Verification
The bench strikes one copy at a time, including each of the three copies, and checks that no output moves. A design that votes wrongly or drives the outputs from a single copy would show the flipped bit. It then strikes a second copy of the same bit after the repair window. A design that flags the upset but never rewrites the copy loses the vote at that point. Strikes made just before or during a shift test that the chain forwards only voted values and raises no flag. The serial output is compared against a reference shift model on every cycle, which exposes an off-by-one stage ordering or a reversed field map.

// File: rtl/tmrcfg_pkg.sv
package tmrcfg_pkg;
    localparam int TRIM_W   = 5;
    localparam int PIX_W    = 8;
    localparam int MASK_POS = 5;
    localparam int TPEN_POS = 6;

    typedef enum logic [1:0] {
        CP_A    = 2'd0,
        CP_B    = 2'd1,
        CP_C    = 2'd2,
        CP_NONE = 2'd3
    } copy_sel_e;
endpackage

// File: rtl/tmr_vote.sv
module tmr_vote #(
    parameter int W = 8
) (
    input  logic [W-1:0] cpy_a,
    input  logic [W-1:0] cpy_b,
    input  logic [W-1:0] cpy_c,
    output logic [W-1:0] voted,
    output logic         disagree
);
    always_comb begin
        voted    = (cpy_a & cpy_b) | (cpy_b & cpy_c) | (cpy_a & cpy_c);
        disagree = |((cpy_a ^ cpy_b) | (cpy_b ^ cpy_c));
    end
endmodule

// File: rtl/upset_mask.sv
module upset_mask #(
    parameter int W     = 8,
    parameter int IDX_W = (W > 1) ? $clog2(W) : 1
) (
    input  logic             en,
    input  logic [IDX_W-1:0] idx,
    output logic [W-1:0]     mask
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        assign mask[i] = en && (idx == IDX_W'(i));
    end
endmodule

// File: rtl/tmr_cfg_chain.sv
module tmr_cfg_chain
    import tmrcfg_pkg::*;
#(
    parameter int COLS        = 4,
    parameter int PIX_PER_COL = 4,
    localparam int NPIX       = COLS * PIX_PER_COL,
    localparam int NBITS      = NPIX * PIX_W,
    localparam int IDX_W      = $clog2(NBITS)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cfg_sdi,
    input  logic                   cfg_shift_en,
    input  logic                   upset_en,
    input  logic [IDX_W-1:0]       upset_bit,
    input  logic [1:0]             upset_copy,
    output logic                   cfg_sdo,
    output logic                   seu_corrected,
    output logic [NPIX*TRIM_W-1:0] pix_trim,
    output logic [NPIX-1:0]        pix_mask,
    output logic [NPIX-1:0]        pix_tpen
);
    typedef struct packed {
        logic [NBITS-1:0] a;
        logic [NBITS-1:0] b;
        logic [NBITS-1:0] c;
        logic             flag;
    } chain_st_t;

    chain_st_t        s_d, s_q;
    logic [NBITS-1:0] vote;
    logic             mismatch;
    logic [NBITS-1:0] hit_mask;
    copy_sel_e        csel;

    assign csel = copy_sel_e'(upset_copy);

    tmr_vote #(.W(NBITS)) u_vote (
        .cpy_a    (s_q.a),
        .cpy_b    (s_q.b),
        .cpy_c    (s_q.c),
        .voted    (vote),
        .disagree (mismatch)
    );

    upset_mask #(.W(NBITS), .IDX_W(IDX_W)) u_mask (
        .en   (upset_en && !cfg_shift_en),
        .idx  (upset_bit),
        .mask (hit_mask)
    );

    always_comb begin
        s_d = s_q;
        if (cfg_shift_en) begin
            s_d.a    = {vote[NBITS-2:0], cfg_sdi};
            s_d.b    = {vote[NBITS-2:0], cfg_sdi};
            s_d.c    = {vote[NBITS-2:0], cfg_sdi};
            s_d.flag = 1'b0;
        end else begin
            s_d.a    = vote ^ ((csel == CP_A) ? hit_mask : '0);
            s_d.b    = vote ^ ((csel == CP_B) ? hit_mask : '0);
            s_d.c    = vote ^ ((csel == CP_C) ? hit_mask : '0);
            s_d.flag = mismatch;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign cfg_sdo       = vote[NBITS-1];
    assign seu_corrected = s_q.flag;

    for (genvar p = 0; p < NPIX; p++) begin : g_pix
        assign pix_trim[p*TRIM_W +: TRIM_W] = vote[p*PIX_W +: TRIM_W];
        assign pix_mask[p]                  = vote[p*PIX_W + MASK_POS];
        assign pix_tpen[p]                  = vote[p*PIX_W + TPEN_POS];
    end

    // R2: stage 0 captures the serial input on a shift
    p_shift_in_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_shift_en |=> (vote[0] == $past(cfg_sdi)));

    // R5: idle chain keeps its voted contents
    p_hold_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_shift_en |=> $stable(vote));

    // R7: a disagreement seen while idle raises the repair flag
    p_flag_raise_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mismatch && !cfg_shift_en) |=> seu_corrected);

    // R8: a repair leaves no disagreement unless a new strike arrives
    p_repair_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_shift_en && !upset_en) |=> !mismatch);

    // R10: no repair flag after a shifting edge
    p_no_flag_shift_r10: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_shift_en |=> !seu_corrected);
endmodule

// File: tb/tmr_cfg_chain_bench.sv
module tmr_cfg_chain_bench;
    localparam int COLS  = 4;
    localparam int PPC   = 4;
    localparam int NPIX  = COLS * PPC;
    localparam int NBITS = NPIX * 8;
    localparam int IDX_W = $clog2(NBITS);

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             cfg_sdi = 1'b0;
    logic             cfg_shift_en = 1'b0;
    logic             upset_en = 1'b0;
    logic [IDX_W-1:0] upset_bit = '0;
    logic [1:0]       upset_copy = 2'd3;
    logic             cfg_sdo;
    logic             seu_corrected;
    logic [NPIX*5-1:0] pix_trim;
    logic [NPIX-1:0]  pix_mask;
    logic [NPIX-1:0]  pix_tpen;

    tmr_cfg_chain #(.COLS(COLS), .PIX_PER_COL(PPC)) u_tmr_cfg_chain (
        .clk, .rst_n, .cfg_sdi, .cfg_shift_en, .upset_en, .upset_bit,
        .upset_copy, .cfg_sdo, .seu_corrected, .pix_trim, .pix_mask, .pix_tpen
    );

    always #5 clk = ~clk;

    typedef struct { logic sdo; logic flg; } item_t;
    item_t q[$];

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [NBITS-1:0] mdl = '0;
    logic             m_flag = 1'b0;
    logic             m_pend = 1'b0;

    task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    // driver: push what the outputs must show this cycle, drive, advance model
    task automatic step(input logic sdi, input logic sh, input logic ue,
                        input int bitn, input logic [1:0] cp);
        item_t it;
        @(negedge clk);
        it.sdo = mdl[NBITS-1];
        it.flg = m_flag;
        q.push_back(it);
        cfg_sdi = sdi; cfg_shift_en = sh; upset_en = ue;
        upset_bit = IDX_W'(bitn); upset_copy = cp;
        m_flag = m_pend && !sh;
        m_pend = ue && !sh && (cp != 2'd3);
        if (sh) mdl = {mdl[NBITS-2:0], sdi};
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(1'b0, 1'b0, 1'b0, 0, 2'd3);
    endtask

    // monitor: compare serial output and repair flag each cycle
    always @(negedge clk) begin
        #2;
        if (q.size() > 0) begin
            item_t it;
            it = q.pop_front();
            chk(cfg_sdo === it.sdo, "R4 sdo", 128'(cfg_sdo), 128'(it.sdo));
            chk(seu_corrected === it.flg, "R7 seu_corrected", 128'(seu_corrected), 128'(it.flg));
        end
    end

    task automatic check_fields(input string tag);
        logic [NPIX*5-1:0] et;
        logic [NPIX-1:0]   em, ep;
        idle(1);
        #3;
        for (int p = 0; p < NPIX; p++) begin
            et[p*5 +: 5] = mdl[p*8 +: 5];
            em[p] = mdl[p*8 + 5];
            ep[p] = mdl[p*8 + 6];
        end
        chk(pix_trim === et, {tag, " trim"}, 128'(pix_trim), 128'(et));
        chk(pix_mask === em, {tag, " mask"}, 128'(pix_mask), 128'(em));
        chk(pix_tpen === ep, {tag, " tpen"}, 128'(pix_tpen), 128'(ep));
    endtask

    task automatic load(input int seed);
        for (int i = 0; i < NBITS; i++)
            step(logic'(((i * seed + (i >> 3)) % 3) == 0), 1'b1, 1'b0, 0, 2'd3);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        #2_000_000;
        errors++;
        checks++;
        $display("FAIL watchdog act=running exp=finished");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        #3;
        chk(pix_trim === '0 && pix_mask === '0 && pix_tpen === '0, "R1 fields", 128'(pix_trim), 128'(0));
        chk(cfg_sdo === 1'b0 && seu_corrected === 1'b0, "R1 sdo/flag", 128'({cfg_sdo, seu_corrected}), 128'(0));
        @(negedge clk);
        rst_n = 1'b1;
        check_fields("R1 after release");

        // R2 R3: load two patterns, fields follow the stage map
        load(7);
        check_fields("R2 R3 pattern A");
        load(5); // R4: the first pattern streams out on cfg_sdo
        check_fields("R2 R3 pattern B");

        // R5: idle holds
        idle(6);
        check_fields("R5 hold");

        // R6 R7: strike each copy of different stages
        for (int cp = 0; cp < 3; cp++) begin
            step(1'b0, 1'b0, 1'b1, 9 + cp * 40, 2'(cp));
            idle(3);
            check_fields("R6 single strike");
        end
        step(1'b0, 1'b0, 1'b1, NBITS - 1, 2'd1);
        idle(2);
        check_fields("R6 last stage strike");

        // R8: repaired copy lets a strike on another copy stay masked
        step(1'b0, 1'b0, 1'b1, 21, 2'd0);
        idle(2);
        step(1'b0, 1'b0, 1'b1, 21, 2'd2);
        idle(2);
        check_fields("R8 repaired in place");

        // R9: strike while shifting and with copy 3 is ignored
        step(1'b1, 1'b1, 1'b1, 3, 2'd0);
        step(1'b0, 1'b1, 1'b1, 4, 2'd1);
        idle(3);
        check_fields("R9 strike during shift");
        step(1'b0, 1'b0, 1'b1, 30, 2'd3);
        idle(3);
        check_fields("R9 copy none");

        // R10: strike then shift at once; only the voted value travels
        step(1'b0, 1'b0, 1'b1, 40, 2'd0);
        load(3);
        check_fields("R10 no spread");
        step(1'b0, 1'b0, 1'b1, 77, 2'd2);
        step(1'b1, 1'b1, 1'b0, 0, 2'd3);
        idle(3);
        check_fields("R10 no flag after shift");
        load(11);
        check_fields("R2 R4 final");

        idle(2);
        finish_run();
    end
endmodule